// File: doc/BRIEF.md
# Write-Protected Configuration Register File for an Ethernet Interface Converter

This block holds the configuration of a small multi-port Ethernet interface converter: a global mode word, one control word per converter port (line rate, interface type, duplex), a per-port converter enable word and two switch-side words. All of these sit behind a write guard. After reset the guard is closed and writes to configuration registers are dropped. Software opens the guard by writing a fixed four-word key, in order, to a single command register. It closes the guard again by writing zero to that same register.

Access is over a simple single-cycle register bus. Write data is taken on the clock edge at which the write strobe is high. Read data is registered: it appears on the cycle after the read strobe and holds until the next read. Reads are never guarded.

When a guarded write arrives while the guard is closed, the write is dropped and a sticky error flag records it. The stored values drive the converter datapath directly through the output ports.

Top module: `xcvr_prot_regfile`

## Requirements
- R1: After reset the guard is closed (`o_unlocked` = 0), every configuration output is zero, and every register reads as zero.
- R2: The guard opens only after four consecutive writes to the command register at offset 0x000 with the 32-bit values 0x000000A5, 0x00000001, 0x0000FFFE, 0x00000001, in that order. `o_unlocked` is 1 from the cycle after the fourth write.
- R3: While the guard is closed, a command-register write that is not the next expected key word sends the key sequence back to its start. That write is not re-tested as the first key word. Accesses to any other address between key words neither advance nor reset the sequence.
- R4: While the guard is open, writing 0 to the command register closes it from the next cycle. Writing any other value to the command register while open has no effect.
- R5: Once open, the guard stays open across any number of guarded writes.
- R6: A write to a guarded register while the guard is closed leaves that register's stored value unchanged.
- R7: Such a dropped write sets bit 0 of the status register at offset 0x00C. The bit stays set until reset. Writes to 0x00C have no effect.
- R8: A read strobe in cycle t puts the addressed register's value on `bus_rdata` from cycle t+1, and the value holds until the next read strobe. Reading the command register returns the guard state in bit 0.
- R9: Port n's control word is at offset 0x100 + 4n (n = 0..4). Its fields are: bits [1:0] rate (0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s), bits [3:2] interface (0 = MII, 1 = RMII, 2 = RGMII), and bit 8 full duplex. All other bits read as zero.
- R10: In the converter enable word at 0x114, bit n enables converter n (bits [4:0]). All other bits read as zero.
- R11: The mode word at 0x008 holds bits [4:0]. The switch control word at 0x304 and the switch duplex word at 0x308 each hold bits [3:0]. Unassigned bits read as zero. Writes and reads to unmapped offsets change nothing, and unmapped reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| o_unlocked | output | 1 | Guard open |
| o_mode | output | 5 | Stored mode word |
| o_conv_spd | output | 10 | Rate field of each port, port n at [2n+1:2n] |
| o_conv_ifm | output | 10 | Interface field of each port, port n at [2n+1:2n] |
| o_conv_fdx | output | 5 | Full-duplex bit of each port |
| o_conv_en | output | 5 | Converter enable of each port |
| o_sw_ctrl | output | 4 | Stored switch control word |
| o_sw_dup | output | 4 | Stored switch duplex word |

## Verification
On every cycle, the assertions check the following. The configuration outputs are frozen whenever the guard is closed. The guard can only open on a write of the final key word, and it only closes on a zero command write. The error flag is raised by a closed-guard guarded write and never drops. Read data holds between read strobes, and a command read reflects the guard state.

Some behaviours can only be shown by the bench's scenarios. These include the exact key order, and the rejection of a repeated first key word. They also include the tolerance of interleaved foreign accesses during the sequence, the field packing of each register, and the return to the closed state after a mid-run reset.

// File: rtl/cvt_prot_pkg.sv
package cvt_prot_pkg;

    // Bus geometry shared by every unit of the register file.
    localparam int CFG_AW = 12;
    localparam int CFG_DW = 32;

    // Register offsets. The command offset and the key order are behavioural;
    // the per-port control words are spaced one word apart.
    localparam logic [CFG_AW-1:0] OFS_CMD   = 12'h000;
    localparam logic [CFG_AW-1:0] OFS_MODE  = 12'h008;
    localparam logic [CFG_AW-1:0] OFS_STAT  = 12'h00C;
    localparam logic [CFG_AW-1:0] OFS_CONV  = 12'h100;
    localparam logic [CFG_AW-1:0] OFS_SWCTL = 12'h304;
    localparam logic [CFG_AW-1:0] OFS_SWDUP = 12'h308;

    // Progress through the key.
    typedef enum logic [1:0] {
        KS_FIRST  = 2'd0,
        KS_SECOND = 2'd1,
        KS_THIRD  = 2'd2,
        KS_FOURTH = 2'd3
    } key_step_e;

    // Which register an address selects.
    typedef enum logic [2:0] {
        RS_NONE = 3'd0,
        RS_CMD  = 3'd1,
        RS_MODE = 3'd2,
        RS_STAT = 3'd3,
        RS_CONV = 3'd4,
        RS_ENA  = 3'd5,
        RS_SWC  = 3'd6,
        RS_SWD  = 3'd7
    } reg_sel_e;

    // Fields of one converter port control word.
    typedef struct packed {
        logic       fdx;
        logic [1:0] ifm;
        logic [1:0] spd;
    } conv_cfg_t;

    // Expected key word for each step.
    function automatic logic [CFG_DW-1:0] key_word(input key_step_e s);
        logic [CFG_DW-1:0] k;
        case (s)
            KS_FIRST:  k = 32'h0000_00A5;
            KS_SECOND: k = 32'h0000_0001;
            KS_THIRD:  k = 32'h0000_FFFE;
            default:   k = 32'h0000_0001;
        endcase
        return k;
    endfunction

    // Registers that the write guard covers.
    function automatic logic is_guarded(input reg_sel_e s);
        return (s == RS_MODE) || (s == RS_CONV) || (s == RS_ENA) ||
               (s == RS_SWC)  || (s == RS_SWD);
    endfunction

    // Bus word to port control fields.
    function automatic conv_cfg_t conv_from_word(input logic [CFG_DW-1:0] w);
        conv_cfg_t c;
        c.spd = w[1:0];
        c.ifm = w[3:2];
        c.fdx = w[8];
        return c;
    endfunction

    // Port control fields to bus word (unassigned bits zero).
    function automatic logic [CFG_DW-1:0] conv_to_word(input conv_cfg_t c);
        logic [CFG_DW-1:0] w;
        w      = '0;
        w[1:0] = c.spd;
        w[3:2] = c.ifm;
        w[8]   = c.fdx;
        return w;
    endfunction

endpackage

// File: rtl/prot_addr_dec.sv
module prot_addr_dec
    import cvt_prot_pkg::*;
#(
    parameter int ADDR_W = CFG_AW,
    parameter int N_PORT = 5,
    localparam int IDX_W = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] CONV_LO = ADDR_W'(OFS_CONV);
    localparam logic [ADDR_W-1:0] CONV_HI = ADDR_W'(OFS_CONV + 4 * N_PORT);
    // The enable word follows the last port control word.
    localparam logic [ADDR_W-1:0] ENA_OFS = CONV_HI;

    logic [ADDR_W-1:0] conv_off;

    assign conv_off = addr - CONV_LO;

    always_comb begin
        sel = RS_NONE;
        idx = '0;
        if (addr == ADDR_W'(OFS_CMD)) begin
            sel = RS_CMD;
        end else if (addr == ADDR_W'(OFS_MODE)) begin
            sel = RS_MODE;
        end else if (addr == ADDR_W'(OFS_STAT)) begin
            sel = RS_STAT;
        end else if (addr >= CONV_LO && addr < CONV_HI && addr[1:0] == 2'b00) begin
            sel = RS_CONV;
            idx = conv_off[IDX_W+1:2];
        end else if (addr == ENA_OFS) begin
            sel = RS_ENA;
        end else if (addr == ADDR_W'(OFS_SWCTL)) begin
            sel = RS_SWC;
        end else if (addr == ADDR_W'(OFS_SWDUP)) begin
            sel = RS_SWD;
        end
    end
endmodule

// File: rtl/prot_key_seq.sv
module prot_key_seq
    import cvt_prot_pkg::*;
#(
    parameter int DATA_W = CFG_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    key_step_e step_q;
    logic      open_q;
    logic      hit;

    assign hit      = (wdata == DATA_W'(key_word(step_q)));
    assign unlocked = open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= KS_FIRST;
            open_q <= 1'b0;
        end else if (cmd_wr) begin
            if (open_q) begin
                // Only a zero word matters while open: it re-arms the guard.
                if (wdata == '0) begin
                    open_q <= 1'b0;
                    step_q <= KS_FIRST;
                end
            end else if (hit) begin
                if (step_q == KS_FOURTH) begin
                    open_q <= 1'b1;
                    step_q <= KS_FIRST;
                end else begin
                    step_q <= key_step_e'(step_q + 2'd1);
                end
            end else begin
                // Wrong word: start over, without re-testing this word.
                step_q <= KS_FIRST;
            end
        end
    end
endmodule

// File: rtl/prot_cfg_bank.sv
module prot_cfg_bank
    import cvt_prot_pkg::*;
#(
    parameter int DATA_W = CFG_DW,
    parameter int N_PORT = 5,
    parameter int MODE_W = 5,
    parameter int SW_W   = 4,
    localparam int IDX_W = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              viol,
    input  reg_sel_e          sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q,
    output conv_cfg_t         conv_q [N_PORT],
    output logic [N_PORT-1:0] ena_q,
    output logic [SW_W-1:0]   swc_q,
    output logic [SW_W-1:0]   swd_q,
    output logic              err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_en && sel == RS_MODE) begin
            mode_q <= wdata[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= '0;
        end else if (wr_en && sel == RS_ENA) begin
            ena_q <= wdata[N_PORT-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            swc_q <= '0;
        end else if (wr_en && sel == RS_SWC) begin
            swc_q <= wdata[SW_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            swd_q <= '0;
        end else if (wr_en && sel == RS_SWD) begin
            swd_q <= wdata[SW_W-1:0];
        end
    end

    // One control word per converter port.
    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                conv_q[p] <= '0;
            end else if (wr_en && sel == RS_CONV && idx == IDX_W'(p)) begin
                conv_q[p] <= conv_from_word(wdata);
            end
        end
    end

    // Sticky record of a guarded write that was dropped.
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (viol) begin
            err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/prot_rd_mux.sv
module prot_rd_mux
    import cvt_prot_pkg::*;
#(
    parameter int DATA_W = CFG_DW,
    parameter int N_PORT = 5,
    parameter int MODE_W = 5,
    parameter int SW_W   = 4,
    localparam int IDX_W = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  reg_sel_e          sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic              unlocked,
    input  logic              err,
    input  logic [MODE_W-1:0] mode_q,
    input  conv_cfg_t         conv_q [N_PORT],
    input  logic [N_PORT-1:0] ena_q,
    input  logic [SW_W-1:0]   swc_q,
    input  logic [SW_W-1:0]   swd_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] conv_word;
    logic [DATA_W-1:0] rd_nxt;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        conv_word = '0;
        for (int p = 0; p < N_PORT; p++) begin
            if (idx == IDX_W'(p)) begin
                conv_word = DATA_W'(conv_to_word(conv_q[p]));
            end
        end
    end

    always_comb begin
        case (sel)
            RS_CMD:  rd_nxt = DATA_W'(unlocked);
            RS_MODE: rd_nxt = DATA_W'(mode_q);
            RS_STAT: rd_nxt = DATA_W'(err);
            RS_CONV: rd_nxt = conv_word;
            RS_ENA:  rd_nxt = DATA_W'(ena_q);
            RS_SWC:  rd_nxt = DATA_W'(swc_q);
            RS_SWD:  rd_nxt = DATA_W'(swd_q);
            default: rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= rd_nxt;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/xcvr_prot_regfile.sv
module xcvr_prot_regfile
    import cvt_prot_pkg::*;
#(
    parameter int ADDR_W = CFG_AW,
    parameter int DATA_W = CFG_DW,
    parameter int N_PORT = 5,
    parameter int MODE_W = 5,
    parameter int SW_W   = 4,
    localparam int IDX_W = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    input  logic                bus_re,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                o_unlocked,
    output logic [MODE_W-1:0]   o_mode,
    output logic [2*N_PORT-1:0] o_conv_spd,
    output logic [2*N_PORT-1:0] o_conv_ifm,
    output logic [N_PORT-1:0]   o_conv_fdx,
    output logic [N_PORT-1:0]   o_conv_en,
    output logic [SW_W-1:0]     o_sw_ctrl,
    output logic [SW_W-1:0]     o_sw_dup
);
    reg_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic              unlocked;
    logic              cmd_wr;
    logic              guarded_wr;
    logic              cfg_wr;
    logic              viol;
    logic              err_q;
    logic [MODE_W-1:0] mode_q;
    conv_cfg_t         conv_q [N_PORT];
    logic [N_PORT-1:0] ena_q;
    logic [SW_W-1:0]   swc_q;
    logic [SW_W-1:0]   swd_q;

    prot_addr_dec #(
        .ADDR_W (ADDR_W),
        .N_PORT (N_PORT)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    assign cmd_wr     = bus_we && (sel == RS_CMD);
    assign guarded_wr = bus_we && is_guarded(sel);
    assign cfg_wr     = guarded_wr && unlocked;
    assign viol       = guarded_wr && !unlocked;

    prot_key_seq #(
        .DATA_W (DATA_W)
    ) u_key (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    prot_cfg_bank #(
        .DATA_W (DATA_W),
        .N_PORT (N_PORT),
        .MODE_W (MODE_W),
        .SW_W   (SW_W)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr),
        .viol   (viol),
        .sel    (sel),
        .idx    (idx),
        .wdata  (bus_wdata),
        .mode_q (mode_q),
        .conv_q (conv_q),
        .ena_q  (ena_q),
        .swc_q  (swc_q),
        .swd_q  (swd_q),
        .err_q  (err_q)
    );

    prot_rd_mux #(
        .DATA_W (DATA_W),
        .N_PORT (N_PORT),
        .MODE_W (MODE_W),
        .SW_W   (SW_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .re       (bus_re),
        .sel      (sel),
        .idx      (idx),
        .unlocked (unlocked),
        .err      (err_q),
        .mode_q   (mode_q),
        .conv_q   (conv_q),
        .ena_q    (ena_q),
        .swc_q    (swc_q),
        .swd_q    (swd_q),
        .rdata    (bus_rdata)
    );

    for (genvar p = 0; p < N_PORT; p++) begin : g_flat
        assign o_conv_spd[2*p +: 2] = conv_q[p].spd;
        assign o_conv_ifm[2*p +: 2] = conv_q[p].ifm;
        assign o_conv_fdx[p]        = conv_q[p].fdx;
    end

    assign o_unlocked = unlocked;
    assign o_mode     = mode_q;
    assign o_conv_en  = ena_q;
    assign o_sw_ctrl  = swc_q;
    assign o_sw_dup   = swd_q;
endmodule

// File: rtl/xcvr_prot_regfile_chk.sv
module xcvr_prot_regfile_chk
    import cvt_prot_pkg::*;
#(
    parameter int ADDR_W = CFG_AW,
    parameter int DATA_W = CFG_DW,
    parameter int N_PORT = 5,
    parameter int MODE_W = 5,
    parameter int SW_W   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_we,
    input logic                bus_re,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                o_unlocked,
    input logic [MODE_W-1:0]   o_mode,
    input logic [2*N_PORT-1:0] o_conv_spd,
    input logic [2*N_PORT-1:0] o_conv_ifm,
    input logic [N_PORT-1:0]   o_conv_fdx,
    input logic [N_PORT-1:0]   o_conv_en,
    input logic [SW_W-1:0]     o_sw_ctrl,
    input logic [SW_W-1:0]     o_sw_dup,
    input logic                err_q
);
    localparam logic [ADDR_W-1:0] C_LO = ADDR_W'(OFS_CONV);
    localparam logic [ADDR_W-1:0] C_HI = ADDR_W'(OFS_CONV + 4 * N_PORT);

    logic cmd_w;
    logic grd_w;

    assign cmd_w = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
    assign grd_w = bus_we && ((bus_addr == ADDR_W'(OFS_MODE)) ||
                              (bus_addr == C_HI) ||
                              (bus_addr == ADDR_W'(OFS_SWCTL)) ||
                              (bus_addr == ADDR_W'(OFS_SWDUP)) ||
                              (bus_addr >= C_LO && bus_addr < C_HI && bus_addr[1:0] == 2'b00));

    AST_CFG_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !o_unlocked |=> $stable({o_mode, o_conv_spd, o_conv_ifm, o_conv_fdx,
                                 o_conv_en, o_sw_ctrl, o_sw_dup})); // R6

    AST_OPEN_ON_LAST_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(o_unlocked) |-> $past(cmd_w && bus_wdata == DATA_W'(32'h1))); // R2

    AST_ZERO_RELOCKS: assert property (@(posedge clk) disable iff (rst)
        (cmd_w && bus_wdata == '0) |=> !o_unlocked); // R4

    AST_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (o_unlocked && !(cmd_w && bus_wdata == '0)) |=> o_unlocked); // R5

    AST_ERR_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (grd_w && !o_unlocked) |=> err_q); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> $stable(bus_rdata)); // R8

    AST_CMD_READ_STATE: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADDR_W'(OFS_CMD)) |=>
            bus_rdata == DATA_W'($past(o_unlocked))); // R8
endmodule

bind xcvr_prot_regfile xcvr_prot_regfile_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_PORT (N_PORT),
    .MODE_W (MODE_W),
    .SW_W   (SW_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .o_unlocked (o_unlocked),
    .o_mode     (o_mode),
    .o_conv_spd (o_conv_spd),
    .o_conv_ifm (o_conv_ifm),
    .o_conv_fdx (o_conv_fdx),
    .o_conv_en  (o_conv_en),
    .o_sw_ctrl  (o_sw_ctrl),
    .o_sw_dup   (o_sw_dup),
    .err_q      (err_q)
);

// File: tb/xcvr_prot_regfile_tb.sv
module xcvr_prot_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        o_unlocked;
    logic [4:0]  o_mode;
    logic [9:0]  o_conv_spd;
    logic [9:0]  o_conv_ifm;
    logic [4:0]  o_conv_fdx;
    logic [4:0]  o_conv_en;
    logic [3:0]  o_sw_ctrl;
    logic [3:0]  o_sw_dup;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xcvr_prot_regfile u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_rdata  (bus_rdata),
        .o_unlocked (o_unlocked),
        .o_mode     (o_mode),
        .o_conv_spd (o_conv_spd),
        .o_conv_ifm (o_conv_ifm),
        .o_conv_fdx (o_conv_fdx),
        .o_conv_en  (o_conv_en),
        .o_sw_ctrl  (o_sw_ctrl),
        .o_sw_dup   (o_sw_dup)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VT [NV] = '{
        '{1'b0, 12'h000, 32'h0,        32'h0,   8'd1 },  // R1 locked at start
        '{1'b1, 12'h008, 32'h1F,       32'h0,   8'd6 },  // R6 dropped write
        '{1'b0, 12'h008, 32'h0,        32'h0,   8'd6 },  // R6 value unchanged
        '{1'b0, 12'h00C, 32'h0,        32'h1,   8'd7 },  // R7 error flag set
        '{1'b1, 12'h000, 32'hA5,       32'h0,   8'd2 },  // R2 key word 1
        '{1'b1, 12'h000, 32'h1,        32'h0,   8'd2 },  // R2 key word 2
        '{1'b0, 12'h008, 32'h0,        32'h0,   8'd3 },  // R3 interleaved read
        '{1'b1, 12'h000, 32'hFFFE,     32'h0,   8'd2 },  // R2 key word 3
        '{1'b1, 12'h000, 32'h1,        32'h0,   8'd2 },  // R2 key word 4
        '{1'b0, 12'h000, 32'h0,        32'h1,   8'd2 },  // R2 guard open
        '{1'b1, 12'h008, 32'hFFFFFFFF, 32'h0,   8'd11},  // R11 mode write
        '{1'b0, 12'h008, 32'h0,        32'h1F,  8'd11},  // R11 mode bits 4:0
        '{1'b1, 12'h100, 32'hFFFFFFFF, 32'h0,   8'd9 },  // R9 port 0 all ones
        '{1'b0, 12'h100, 32'h0,        32'h10F, 8'd9 },  // R9 fields only
        '{1'b1, 12'h110, 32'h106,      32'h0,   8'd9 },  // R9 port 4 1G RMII FD
        '{1'b0, 12'h110, 32'h0,        32'h106, 8'd9 },  // R9
        '{1'b1, 12'h114, 32'hFF,       32'h0,   8'd10},  // R10 enables
        '{1'b0, 12'h114, 32'h0,        32'h1F,  8'd10},  // R10 bits 4:0
        '{1'b1, 12'h304, 32'hA,        32'h0,   8'd11},  // R11 switch ctrl
        '{1'b0, 12'h304, 32'h0,        32'hA,   8'd11},  // R11
        '{1'b1, 12'h308, 32'hFFFF,     32'h0,   8'd11},  // R11 switch duplex
        '{1'b0, 12'h308, 32'h0,        32'hF,   8'd11},  // R11 bits 3:0
        '{1'b1, 12'h000, 32'h5,        32'h0,   8'd4 },  // R4 nonzero ignored
        '{1'b0, 12'h000, 32'h0,        32'h1,   8'd4 },  // R4 still open
        '{1'b1, 12'h000, 32'h0,        32'h0,   8'd4 },  // R4 zero relocks
        '{1'b0, 12'h000, 32'h0,        32'h0,   8'd4 },  // R4 closed
        '{1'b1, 12'h114, 32'h0,        32'h0,   8'd6 },  // R6 dropped clear
        '{1'b0, 12'h114, 32'h0,        32'h1F,  8'd6 },  // R6 enables kept
        '{1'b1, 12'h200, 32'hFFFFFFFF, 32'h0,   8'd11},  // R11 unmapped write
        '{1'b0, 12'h200, 32'h0,        32'h0,   8'd11}   // R11 unmapped read
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic unlock();
        wr(12'h000, 32'hA5);
        wr(12'h000, 32'h1);
        wr(12'h000, 32'hFFFE);
        wr(12'h000, 32'h1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state at the ports and through reads
        chk("R1 unlocked", {31'b0, o_unlocked}, 32'h0);
        chk("R1 outputs", {o_mode, o_conv_spd, o_conv_ifm, o_conv_fdx, o_conv_en,
                           o_sw_ctrl, o_sw_dup}, 32'h0);
        rd(12'h100, 32'h0, "R1 port0 read");
        rd(12'h114, 32'h0, "R1 enable read");
        rd(12'h00C, 32'h0, "R1 status read");

        for (int i = 0; i < NV; i++) begin
            if (VT[i].wr) begin
                wr(VT[i].addr, VT[i].data);
            end else begin
                rd(VT[i].addr, VT[i].exp, $sformatf("R%0d vector %0d", VT[i].req, i));
            end
        end

        // R7: status word ignores writes and stays set
        wr(12'h00C, 32'h0);
        rd(12'h00C, 32'h1, "R7 status write ignored");

        // R3: repeated first key word is not re-tested
        wr(12'h000, 32'hA5);
        wr(12'h000, 32'hA5);
        wr(12'h000, 32'h1);
        wr(12'h000, 32'hFFFE);
        wr(12'h000, 32'h1);
        chk("R3 repeated first word", {31'b0, o_unlocked}, 32'h0);

        // R3: wrong third word restarts
        wr(12'h000, 32'hA5);
        wr(12'h000, 32'h1);
        wr(12'h000, 32'h7);
        wr(12'h000, 32'hFFFE);
        wr(12'h000, 32'h1);
        chk("R3 wrong word restarts", {31'b0, o_unlocked}, 32'h0);

        // R3: foreign accesses between key words are harmless
        wr(12'h000, 32'hA5);
        wr(12'h200, 32'h0);
        wr(12'h000, 32'h1);
        rd(12'h304, 32'hA, "R3 interleaved read value");
        wr(12'h000, 32'hFFFE);
        wr(12'h008, 32'h3);
        wr(12'h000, 32'h1);
        chk("R3 open after interleaving", {31'b0, o_unlocked}, 32'h1);
        chk("R6 write during sequence dropped", {27'b0, o_mode}, 32'h1F);

        // R5: many guarded writes keep the guard open
        for (int p = 0; p < 5; p++) begin
            wr(12'h100 + 12'(4 * p), {23'b0, p[0], 4'b0, 2'(p + 1), 2'(p)});
        end
        for (int p = 0; p < 5; p++) begin
            chk($sformatf("R9 port %0d rate", p), {30'b0, o_conv_spd[2*p +: 2]}, 32'(p % 4));
            chk($sformatf("R9 port %0d intf", p), {30'b0, o_conv_ifm[2*p +: 2]}, 32'((p + 1) % 4));
            chk($sformatf("R9 port %0d fdx", p), {31'b0, o_conv_fdx[p]}, 32'(p % 2));
        end
        wr(12'h114, 32'h15);
        chk("R10 enable outputs", {27'b0, o_conv_en}, 32'h15);
        chk("R5 still open", {31'b0, o_unlocked}, 32'h1);

        // R8: read data holds without a strobe
        rd(12'h114, 32'h15, "R8 read enable");
        bus_addr = 12'h304;
        @(negedge clk);
        @(negedge clk);
        chk("R8 rdata held", bus_rdata, 32'h15);

        // R1: mid-run reset returns to the closed, zeroed state
        do_reset();
        chk("R1 relocked", {31'b0, o_unlocked}, 32'h0);
        chk("R1 cleared", {o_mode, o_conv_spd, o_conv_ifm, o_conv_fdx, o_conv_en,
                           o_sw_ctrl, o_sw_dup}, 32'h0);
        rd(12'h00C, 32'h0, "R7 error cleared by reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule